// File: doc/BRIEF.md
# Hit address and timestamp sparsifier

This block turns one scanned pixel column into a compact list of hit words. Each cycle it may receive the 8-bit hit pattern of one column, with the column's position inside its macro-pixel and the address of its macro-column. In a single clock it emits one formatted word for every set bit. Each word carries the pixel row, the in-macro-pixel column, the macro-column address and an 8-bit time stamp. The words are packed into the low slots of an 8-slot bus, and a count of valid words from 0 to 8 comes with them.

The block also keeps the time-stamp counter. The counter advances on each rising edge of the bunch-crossing strobe. At that same edge the value that was just closed is captured as the frozen stamp. Hits waiting in the matrix belong to the window that has just ended, so every word is tagged with the frozen stamp and not with the live counter. A downstream FIFO takes the bus and the count. Buffering is not part of this block.

Top module: `hit_sparsifier`

## Requirements
- R1: Each 17-bit word is laid out as: bit 16 data valid, bits 15:13 pixel row, bits 12:11 column within the macro-pixel, bits 10:8 macro-column address, bits 7:0 time stamp. Slot k of the bus occupies bits k*17+16 down to k*17.
- R2: A column sampled with col_valid high at a rising clock edge appears on the bus and count one clock later. One new column can be accepted every cycle.
- R3: hit_cnt equals the number of set bits in the sampled hit vector, from 0 to 8.
- R4: Valid words fill slots 0 to hit_cnt-1, in strictly ascending row order. Every slot at or above hit_cnt is all zero, with its valid bit clear.
- R5: A cycle with col_valid low gives a count of 0 and an all-zero bus on the next clock, whatever the hit vector holds. A valid column with no hits gives the same result.
- R6: ts_count increments by one on each rising edge of bx_strobe and wraps from 255 to 0. A strobe that is held high for several cycles advances it only once.
- R7: Words carry the frozen stamp: the ts_count value from just before the most recent strobe rising edge, or 0 if no strobe has arrived since reset. A column sampled at the same clock edge as a strobe rising edge uses the stamp that was frozen before that edge.
- R8: While rst is high at a clock edge, ts_count, the frozen stamp, hit_cnt and the whole bus are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | Bunch-crossing strobe; its rising edge closes a time window |
| col_valid | input | 1 | A scanned column is present this cycle |
| col_hits | input | 8 | Hit vector of the column, bit r = pixel row r |
| mc_addr | input | 3 | Macro-column address of the column |
| pix_col | input | 2 | Column position inside the macro-pixel |
| word_bus | output | 136 | Eight 17-bit hit words, slot 0 in the low bits |
| hit_cnt | output | 4 | Number of valid words on the bus |
| ts_count | output | 8 | Live time-stamp counter |

## Verification
The bench drives sparse, dense, full and empty columns, and also lone hits in rows 0 and 7. A compactor with a wrong rank or an off-by-one slot index would leave gaps, duplicate a row or drop the top row. It also sends hit patterns while col_valid is low. A design that ignored the qualifier would report phantom words there. On the time stamp side, the bench holds the strobe high for several cycles, takes the counter through the 255-to-0 wrap, and lines a column up with a strobe edge. A counter that works on the level would over-count. A design that tags words with the live value would show a stamp that is one too high.

// File: rtl/sparsify_pkg.sv
package sparsify_pkg;

    // Geometry of one scanned column and of the word fields
    localparam int ROWS   = 8;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int PCOL_W = 2;
    localparam int MC_W   = 3;
    localparam int TS_W   = 8;
    localparam int CNT_W  = $clog2(ROWS + 1);

    // Field order matters: the downstream FIFO decodes it (MSB first)
    typedef struct packed {
        logic              valid;
        logic [ROW_W-1:0]  row;
        logic [PCOL_W-1:0] pcol;
        logic [MC_W-1:0]   mc;
        logic [TS_W-1:0]   ts;
    } hit_word_t;

    localparam int WORD_W = $bits(hit_word_t);
    localparam int BUS_W  = ROWS * WORD_W;

    // Per-column context carried alongside the hit vector
    typedef struct packed {
        logic [PCOL_W-1:0] pcol;
        logic [MC_W-1:0]   mc;
        logic [TS_W-1:0]   ts;
    } col_ctx_t;

    function automatic hit_word_t make_word(input logic [ROW_W-1:0] row,
                                            input col_ctx_t ctx);
        hit_word_t w;
        w.valid = 1'b1;
        w.row   = row;
        w.pcol  = ctx.pcol;
        w.mc    = ctx.mc;
        w.ts    = ctx.ts;
        return w;
    endfunction

endpackage

// File: rtl/sp_stamp.sv
module sp_stamp
    import sparsify_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    output logic [TS_W-1:0] ts_live,
    output logic [TS_W-1:0] ts_frozen
);
    logic strobe_q;
    logic window_edge;

    assign window_edge = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q  <= 1'b0;
            ts_live   <= '0;
            ts_frozen <= '0;
        end else begin
            strobe_q <= strobe;
            if (window_edge) begin
                ts_frozen <= ts_live;            // close the running window
                ts_live   <= ts_live + 1'b1;     // natural modulo 2^TS_W wrap
            end
        end
    end
endmodule

// File: rtl/sp_compact.sv
module sp_compact
    import sparsify_pkg::*;
(
    input  logic [ROWS-1:0]  hits,
    output logic [ROWS-1:0]  slot_used,
    output logic [ROW_W-1:0] slot_row [ROWS],
    output logic [CNT_W-1:0] total
);
    // rank[i] = number of hits strictly below row i
    logic [CNT_W-1:0] rank [ROWS];

    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < ROWS; i++) begin
            rank[i] = acc;
            acc     = acc + CNT_W'(hits[i]);
        end
        total = acc;
    end

    // Each slot selects the single row whose rank equals the slot index
    for (genvar k = 0; k < ROWS; k++) begin : g_slot
        always_comb begin
            slot_used[k] = 1'b0;
            slot_row[k]  = '0;
            for (int i = 0; i < ROWS; i++) begin
                if (hits[i] && (rank[i] == CNT_W'(k))) begin
                    slot_used[k] = 1'b1;
                    slot_row[k]  = slot_row[k] | ROW_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/sp_format.sv
module sp_format
    import sparsify_pkg::*;
(
    input  logic [ROWS-1:0]  slot_used,
    input  logic [ROW_W-1:0] slot_row [ROWS],
    input  col_ctx_t         ctx,
    output logic [BUS_W-1:0] bus
);
    for (genvar k = 0; k < ROWS; k++) begin : g_word
        hit_word_t w;
        always_comb begin
            if (slot_used[k]) w = make_word(slot_row[k], ctx);
            else              w = '0;
        end
        assign bus[k*WORD_W +: WORD_W] = w;
    end
endmodule

// File: rtl/hit_sparsifier.sv
module hit_sparsifier
    import sparsify_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_strobe,
    input  logic              col_valid,
    input  logic [ROWS-1:0]   col_hits,
    input  logic [MC_W-1:0]   mc_addr,
    input  logic [PCOL_W-1:0] pix_col,
    output logic [BUS_W-1:0]  word_bus,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [TS_W-1:0]   ts_count
);
    logic [TS_W-1:0]  ts_frozen;
    logic [ROWS-1:0]  gated_hits;
    logic [ROWS-1:0]  slot_used;
    logic [ROW_W-1:0] slot_row [ROWS];
    logic [CNT_W-1:0] total;
    logic [BUS_W-1:0] bus_next;
    col_ctx_t         ctx;

    sp_stamp u_stamp (
        .clk       (clk),
        .rst       (rst),
        .strobe    (bx_strobe),
        .ts_live   (ts_count),
        .ts_frozen (ts_frozen)
    );

    assign gated_hits = col_valid ? col_hits : '0;

    sp_compact u_compact (
        .hits      (gated_hits),
        .slot_used (slot_used),
        .slot_row  (slot_row),
        .total     (total)
    );

    always_comb begin
        ctx.pcol = pix_col;
        ctx.mc   = mc_addr;
        ctx.ts   = ts_frozen;
    end

    sp_format u_format (
        .slot_used (slot_used),
        .slot_row  (slot_row),
        .ctx       (ctx),
        .bus       (bus_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_bus <= '0;
            hit_cnt  <= '0;
        end else begin
            word_bus <= bus_next;
            hit_cnt  <= total;
        end
    end
endmodule

// File: rtl/hit_sparsifier_chk.sv
module hit_sparsifier_chk
    import sparsify_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bx_strobe,
    input logic              col_valid,
    input logic [ROWS-1:0]   col_hits,
    input logic [MC_W-1:0]   mc_addr,
    input logic [PCOL_W-1:0] pix_col,
    input logic [BUS_W-1:0]  word_bus,
    input logic [CNT_W-1:0]  hit_cnt,
    input logic [TS_W-1:0]   ts_count
);
    logic [ROWS-1:0] vbits;
    for (genvar k = 0; k < ROWS; k++) begin : g_v
        assign vbits[k] = word_bus[k*WORD_W + WORD_W - 1];
    end

    // R3: count never exceeds the column height
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        hit_cnt <= CNT_W'(ROWS));

    // R3: count tracks the popcount of the sampled column
    a_r3_cnt_pop: assert property (@(posedge clk) disable iff (rst)
        col_valid |=> hit_cnt == CNT_W'($countones($past(col_hits))));

    // R4: number of valid bits equals the count
    a_r4_valid_count: assert property (@(posedge clk) disable iff (rst)
        $countones(vbits) == int'(hit_cnt));

    // R4: valid words contiguous from slot 0, rows strictly ascending
    for (genvar k = 0; k + 1 < ROWS; k++) begin : g_ord
        a_r4_packed: assert property (@(posedge clk) disable iff (rst)
            vbits[k+1] |-> vbits[k]);
        a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
            vbits[k+1] |-> (word_bus[(k+1)*WORD_W + 13 +: 3] > word_bus[k*WORD_W + 13 +: 3]));
    end

    // R5: an idle cycle gives an empty bus
    a_r5_idle_empty: assert property (@(posedge clk) disable iff (rst)
        !col_valid |=> (hit_cnt == '0) && (word_bus == '0));

    // R1: slot 0 carries the column addresses
    a_r1_fields: assert property (@(posedge clk) disable iff (rst)
        (col_valid && (col_hits != '0)) |=>
            vbits[0] && (word_bus[12:11] == $past(pix_col)) && (word_bus[10:8] == $past(mc_addr)));

    // R6: strobe rising edge advances the counter by one
    a_r6_ts_step: assert property (@(posedge clk) disable iff (rst)
        $rose(bx_strobe) |=> ts_count == $past(ts_count) + 8'd1);

    // R6: no strobe edge, no change
    a_r6_ts_hold: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> $stable(ts_count));
endmodule

bind hit_sparsifier hit_sparsifier_chk i_chk (.*);

// File: tb/test_hit_sparsifier.sv
module test_hit_sparsifier;
    import sparsify_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              bx_strobe;
    logic              col_valid;
    logic [ROWS-1:0]   col_hits;
    logic [MC_W-1:0]   mc_addr;
    logic [PCOL_W-1:0] pix_col;
    logic [BUS_W-1:0]  word_bus;
    logic [CNT_W-1:0]  hit_cnt;
    logic [TS_W-1:0]   ts_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_live   = 8'd0;
    logic [7:0] m_frozen = 8'd0;

    always #2.5 clk = ~clk;   // 200 MHz

    hit_sparsifier i_hit_sparsifier (.*);

    typedef struct packed {
        logic [7:0] hits;
        logic [2:0] mc;
        logic [1:0] pc;
        logic [3:0] exp_cnt;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h00, 3'd1, 2'd0, 4'd0},
        '{8'h01, 3'd2, 2'd1, 4'd1},
        '{8'h80, 3'd7, 2'd3, 4'd1},
        '{8'hFF, 3'd5, 2'd2, 4'd8},
        '{8'hA5, 3'd3, 2'd0, 4'd4},
        '{8'h5A, 3'd6, 2'd1, 4'd4},
        '{8'h81, 3'd0, 2'd2, 4'd2},
        '{8'h7E, 3'd4, 2'd3, 4'd6},
        '{8'h10, 3'd1, 2'd1, 4'd1},
        '{8'hFE, 3'd2, 2'd0, 4'd7}
    };

    function automatic logic [BUS_W-1:0] expect_bus(input logic [7:0] h, input logic [2:0] mc,
                                                    input logic [1:0] pc, input logic [7:0] ts);
        logic [BUS_W-1:0] b;
        int slot;
        b = '0;
        slot = 0;
        for (int r = 0; r < 8; r++) begin
            if (h[r]) begin
                b[slot*17 +: 17] = {1'b1, 3'(r), pc, mc, ts};
                slot++;
            end
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one column, sample its result one clock later
    task automatic run_col(input logic [7:0] h, input logic [2:0] mc, input logic [1:0] pc,
                           input string req);
        logic [BUS_W-1:0] eb;
        @(negedge clk);
        col_valid = 1'b1; col_hits = h; mc_addr = mc; pix_col = pc;
        eb = expect_bus(h, mc, pc, m_frozen);
        @(negedge clk);
        col_valid = 1'b0; col_hits = '0;
        check(hit_cnt == 4'($countones(h)), req, "count", BUS_W'(hit_cnt), BUS_W'($countones(h)));
        check(word_bus == eb, req, "bus", word_bus, eb);
    endtask

    task automatic pulse_strobe(input int width);
        @(negedge clk);
        bx_strobe = 1'b1;
        m_frozen = m_live;
        m_live   = m_live + 8'd1;
        repeat (width) @(negedge clk);
        bx_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bx_strobe = 1'b0; col_valid = 1'b1; col_hits = 8'hFF;
        mc_addr = 3'd7; pix_col = 2'd3;
        repeat (3) @(negedge clk);
        // R8: reset clears everything even with a full column present
        check(hit_cnt == '0, "R8", "count in reset", BUS_W'(hit_cnt), '0);
        check(word_bus == '0, "R8", "bus in reset", word_bus, '0);
        check(ts_count == '0, "R8", "counter in reset", BUS_W'(ts_count), '0);
        col_valid = 1'b0; col_hits = '0;
        rst = 1'b0;

        // R7: before any strobe the stamp is 0; R1, R2, R3, R4 via table
        foreach (VECS[i]) begin
            run_col(VECS[i].hits, VECS[i].mc, VECS[i].pc, "R1/R4");
            check(hit_cnt == VECS[i].exp_cnt, "R3", "table count",
                  BUS_W'(hit_cnt), BUS_W'(VECS[i].exp_cnt));
        end

        // R5: hits present but col_valid low are ignored
        @(negedge clk);
        col_valid = 1'b0; col_hits = 8'hC3; mc_addr = 3'd5;
        @(negedge clk);
        check(hit_cnt == '0, "R5", "idle count", BUS_W'(hit_cnt), '0);
        check(word_bus == '0, "R5", "idle bus", word_bus, '0);
        col_hits = '0;

        // R6: a held strobe advances the counter once
        pulse_strobe(5);
        @(negedge clk);
        check(ts_count == m_live, "R6", "held strobe", BUS_W'(ts_count), BUS_W'(m_live));
        // R7: words carry the frozen stamp, not the live counter
        run_col(8'h24, 3'd3, 2'd2, "R7");

        // R2: back-to-back columns, one per cycle
        @(negedge clk);
        col_valid = 1'b1; col_hits = 8'h03; mc_addr = 3'd1; pix_col = 2'd1;
        @(negedge clk);
        check(word_bus == expect_bus(8'h03, 3'd1, 2'd1, m_frozen), "R2", "first of pair",
              word_bus, expect_bus(8'h03, 3'd1, 2'd1, m_frozen));
        col_hits = 8'h40; mc_addr = 3'd6; pix_col = 2'd0;
        @(negedge clk);
        check(word_bus == expect_bus(8'h40, 3'd6, 2'd0, m_frozen), "R2", "second of pair",
              word_bus, expect_bus(8'h40, 3'd6, 2'd0, m_frozen));
        col_valid = 1'b0; col_hits = '0;

        // R7: column and strobe edge on the same clock use the older stamp
        repeat (3) pulse_strobe(1);
        @(negedge clk);
        begin
            logic [BUS_W-1:0] eb;
            eb = expect_bus(8'h11, 3'd2, 2'd3, m_frozen);
            col_valid = 1'b1; col_hits = 8'h11; mc_addr = 3'd2; pix_col = 2'd3;
            bx_strobe = 1'b1;
            m_frozen = m_live; m_live = m_live + 8'd1;
            @(negedge clk);
            col_valid = 1'b0; col_hits = '0; bx_strobe = 1'b0;
            check(word_bus == eb, "R7", "coincident strobe", word_bus, eb);
            check(ts_count == m_live, "R6", "coincident count", BUS_W'(ts_count), BUS_W'(m_live));
        end

        // R6: wrap from 255 to 0
        while (m_live != 8'd255) pulse_strobe(1);
        @(negedge clk);
        check(ts_count == 8'd255, "R6", "before wrap", BUS_W'(ts_count), BUS_W'(8'd255));
        pulse_strobe(1);
        @(negedge clk);
        check(ts_count == 8'd0, "R6", "after wrap", BUS_W'(ts_count), '0);
        run_col(8'h80, 3'd7, 2'd1, "R7 stamp 255");
        check(word_bus[7:0] == 8'd255, "R7", "wrapped stamp", BUS_W'(word_bus[7:0]), BUS_W'(8'd255));

        // R8: mid-run reset clears counter and bus
        @(negedge clk);
        col_valid = 1'b1; col_hits = 8'h0F; rst = 1'b1;
        @(negedge clk);
        check(ts_count == '0 && word_bus == '0 && hit_cnt == '0, "R8", "mid-run reset",
              word_bus, '0);
        rst = 1'b0; col_valid = 1'b0; col_hits = '0;
        m_live = 8'd0; m_frozen = 8'd0;
        run_col(8'h09, 3'd4, 2'd2, "R8 stamp after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule